// File: doc/BRIEF.md
# Bus Master Write-Back Backoff Sequencer

This block runs bus-master accesses on a local bus out of a small in-order queue. The logic that fills the queue pushes accesses into it. Each access carries an address, a direction and write data. When the bus is granted, the block drives the oldest access onto the master signals. A ready input completes the access, and only a completed access leaves the queue. Read data returned on completion is passed on with a one-cycle valid pulse.

A cache may need the bus for a write-back. It raises a write-back input to ask for this. While the block is mastering, that input makes the block release every master signal by the next clock. The interrupted access stays at the head of the queue. Once the input falls, the block drives the same access again, with the same address, direction and data, before any later entry. Losing the grant has the same effect. Slave register cycles are refused while the write-back input is high. A slave request that arrives in that window is remembered and acknowledged once the input falls.

A released signal is modelled by a low drive-enable output, and the data outputs are held at zero while the drive enable is low.

Top module: `wbk_master_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `m_drive`, `m_start`, `rd_valid`, `s_ack` and `s_pending` are 0, and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 whenever QDEPTH accesses are queued, and a request offered then is discarded.
- R3: If the queue is not empty and at a clock edge `bus_grant` is 1 and `wb_hold` is 0, an idle block drives the oldest access from the next cycle. `m_drive` is 1 and `m_start` is 1 in that first cycle only. `m_wr` is 1 for a write and 0 for a read, and `m_addr`/`m_wdata` stay stable until the access ends.
- R4: An edge with `m_drive`, `bus_rdy` and `bus_grant` all 1 and `wb_hold` 0 completes the access. It is removed from the queue and `m_drive` is 0 in the next cycle. For a read, `rd_valid` is 1 for that one cycle and `rd_data` holds the `bus_rdata` sampled at that edge.
- R5: When `wb_hold` is 1 at an edge while `m_drive` is 1, `m_drive` is 0 from the next cycle. The access is not completed, even if `bus_rdy` is 1 at that edge.
- R6: After a write-back backoff, the first edge with `wb_hold` 0 and `bus_grant` 1 restarts the suspended access, with `m_start` pulsing again and the same address, direction and data. Later queued accesses follow in order.
- R7: When `bus_grant` is 0 at an edge while `m_drive` is 1, the access is suspended and retried exactly as in R5 and R6.
- R8: While `m_drive` is 0, `m_start` and `m_wr` are 0, and `m_addr` and `m_wdata` are all zeros.
- R9: `s_ack` is never 1 in the cycle after an edge where `wb_hold` was 1. A `s_req` pulse seen while `wb_hold` is 1 sets `s_pending`. The first edge with `wb_hold` 0 then clears `s_pending`, and `s_ack` pulses for one cycle after that edge.
- R10: A `s_req` pulse with `wb_hold` 0 gives a one-cycle `s_ack` pulse in the next cycle.
- R11: No access starts while `wb_hold` is 1 or `bus_grant` is 0. An idle block stays with `m_drive` 0 through such edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Queue push request |
| req_wr | input | 1 | Direction of the pushed access, 1 = write |
| req_addr | input | ADDR_W | Address of the pushed access |
| req_wdata | input | DATA_W | Write data of the pushed access |
| req_ready | output | 1 | Queue has room |
| bus_grant | input | 1 | Bus mastership granted |
| wb_hold | input | 1 | Cache write-back in progress |
| bus_rdy | input | 1 | Current master access completes |
| bus_rdata | input | DATA_W | Read data from the bus |
| m_drive | output | 1 | Master signals are driven (0 = released) |
| m_start | output | 1 | First cycle of a driven access |
| m_wr | output | 1 | Write/read indication, 1 = write |
| m_addr | output | ADDR_W | Master address |
| m_wdata | output | DATA_W | Master write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data |
| s_req | input | 1 | Slave register access request pulse |
| s_ack | output | 1 | Slave access serviced pulse |
| s_pending | output | 1 | Slave request held off by write-back |

## Verification
The bench builds the block with QDEPTH=2 and 16-bit address and data. With that depth, two pushes fill the queue, so the back-pressure and discard path is reached quickly. The backoff runs cover a write-back that lands in the same cycle as a ready, and a write-back that holds a slave request pending. They also cover a grant loss in the middle of an access and a write-back that holds off an idle start. Ordering is checked by queueing two accesses and confirming that the interrupted one reappears unchanged before its successor.

// File: rtl/wbk_pkg.sv
package wbk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACTIVE  = 2'd1,
        SEQ_BACKOFF = 2'd2
    } seq_state_e;

    // Mastership must be given up (or not taken) in this cycle.
    function automatic logic must_yield(input logic wb, input logic grant);
        return wb || !grant;
    endfunction

    function automatic int acc_bits(input int aw, input int dw);
        return 1 + aw + dw;
    endfunction

endpackage

// File: rtl/wbk_queue.sv
module wbk_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wbk_master_fsm.sv
module wbk_master_fsm
    import wbk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic wb,
    input  logic rdy,
    input  logic q_empty,
    output logic drive,
    output logic start,
    output logic complete
);
    seq_state_e st;
    logic       start_q;
    logic       yield;

    assign yield    = must_yield(wb, grant);
    assign drive    = (st == SEQ_ACTIVE);
    assign start    = start_q;
    assign complete = (st == SEQ_ACTIVE) && !yield && rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (!q_empty && !yield) begin
                        st      <= SEQ_ACTIVE;
                        start_q <= 1'b1;
                    end
                end
                SEQ_ACTIVE: begin
                    if (yield)    st <= SEQ_BACKOFF;
                    else if (rdy) st <= SEQ_IDLE;
                end
                SEQ_BACKOFF: begin
                    if (!yield) begin
                        st      <= SEQ_ACTIVE;
                        start_q <= 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbk_slave_gate.sv
module wbk_slave_gate (
    input  logic clk,
    input  logic rst,
    input  logic s_req,
    input  logic wb,
    output logic s_ack,
    output logic s_pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s_ack     <= 1'b0;
            s_pending <= 1'b0;
        end else begin
            s_ack <= 1'b0;
            if ((s_req || s_pending) && !wb) begin
                s_ack     <= 1'b1;
                s_pending <= 1'b0;
            end else if (s_req) begin
                s_pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbk_master_seq.sv
module wbk_master_seq
    import wbk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              bus_grant,
    input  logic              wb_hold,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              m_drive,
    output logic              m_start,
    output logic              m_wr,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              s_req,
    output logic              s_ack,
    output logic              s_pending
);
    localparam int AW = acc_bits(ADDR_W, DATA_W);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } access_t;

    access_t in_acc, head;
    logic    q_empty, q_full, drive, start, complete;

    assign in_acc = '{wr: req_wr, addr: req_addr, data: req_wdata};
    assign req_ready = !q_full;

    wbk_queue #(.W(AW), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (req_valid),
        .din   (in_acc),
        .pop   (complete),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    wbk_master_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .grant    (bus_grant),
        .wb       (wb_hold),
        .rdy      (bus_rdy),
        .q_empty  (q_empty),
        .drive    (drive),
        .start    (start),
        .complete (complete)
    );

    wbk_slave_gate u_slave (
        .clk       (clk),
        .rst       (rst),
        .s_req     (s_req),
        .wb        (wb_hold),
        .s_ack     (s_ack),
        .s_pending (s_pending)
    );

    // Released master signals are parked at zero.
    assign m_drive = drive;
    assign m_start = drive && start;
    assign m_wr    = drive && head.wr;
    assign m_addr  = drive ? head.addr : '0;
    assign m_wdata = drive ? head.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= complete && !head.wr;
            if (complete && !head.wr) rd_data <= bus_rdata;
        end
    end
endmodule

// File: rtl/wbk_master_seq_chk.sv
module wbk_master_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_grant,
    input logic              wb_hold,
    input logic              bus_rdy,
    input logic              m_drive,
    input logic              m_start,
    input logic              m_wr,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              s_ack
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (m_drive && !bus_rdy && !wb_hold && bus_grant) |=>
            (m_drive && !m_start && $stable(m_addr) && $stable(m_wr) && $stable(m_wdata)));

    assert_done_R4: assert property (@(posedge clk) disable iff (rst)
        (m_drive && bus_rdy && !wb_hold && bus_grant) |=> !m_drive);

    assert_wb_float_R5: assert property (@(posedge clk) disable iff (rst)
        (m_drive && wb_hold) |=> !m_drive);

    assert_grant_float_R7: assert property (@(posedge clk) disable iff (rst)
        (m_drive && !bus_grant) |=> !m_drive);

    assert_parked_R8: assert property (@(posedge clk) disable iff (rst)
        !m_drive |-> (!m_start && !m_wr && m_addr == '0 && m_wdata == '0));

    assert_slave_block_R9: assert property (@(posedge clk) disable iff (rst)
        wb_hold |=> !s_ack);

    assert_no_start_R11: assert property (@(posedge clk) disable iff (rst)
        (!m_drive && (wb_hold || !bus_grant)) |=> !m_drive);
endmodule

bind wbk_master_seq wbk_master_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_grant (bus_grant),
    .wb_hold   (wb_hold),
    .bus_rdy   (bus_rdy),
    .m_drive   (m_drive),
    .m_start   (m_start),
    .m_wr      (m_wr),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .s_ack     (s_ack)
);

// File: tb/sim_wbk_master_seq.sv
module sim_wbk_master_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
    logic          req_ready, bus_grant = 1'b0, wb_hold = 1'b0, bus_rdy = 1'b0;
    logic          m_drive, m_start, m_wr, rd_valid, s_req = 1'b0, s_ack, s_pending;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wbk_master_seq #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(2)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_grant(bus_grant), .wb_hold(wb_hold), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata), .m_drive(m_drive), .m_start(m_start),
        .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .s_req(s_req), .s_ack(s_ack), .s_pending(s_pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock edge; returns at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        step();
        req_valid = 1'b0;
    endtask

    task automatic finish_access();
        bus_rdy = 1'b1;
        step();
        bus_rdy = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 m_drive", m_drive, 0);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 s_ack", s_ack, 0);
        chk("R1 s_pending", s_pending, 0);
        chk("R1 rd_valid", rd_valid, 0);
        rst = 1'b0;
        step();
        chk("R1 m_drive after release", m_drive, 0);
        chk("R1 m_start after release", m_start, 0);
    endtask

    task automatic t_write();
        push(1'b1, 16'h1234, 16'hBEEF);
        chk("R8 no grant drive", m_drive, 0);
        chk("R8 parked addr", m_addr, 0);
        step();
        chk("R11 no grant no start", m_drive, 0);
        bus_grant = 1'b1;
        step();
        chk("R3 drive", m_drive, 1);
        chk("R3 start", m_start, 1);
        chk("R3 addr", m_addr, 16'h1234);
        chk("R3 wr", m_wr, 1);
        chk("R3 wdata", m_wdata, 16'hBEEF);
        step();
        chk("R3 start one cycle", m_start, 0);
        chk("R3 addr held", m_addr, 16'h1234);
        finish_access();
        chk("R4 released after ready", m_drive, 0);
        chk("R4 no rd_valid on write", rd_valid, 0);
        chk("R8 wr parked", m_wr, 0);
        chk("R8 wdata parked", m_wdata, 0);
    endtask

    task automatic t_read();
        push(1'b0, 16'h0040, 16'h0000);
        step();
        chk("R3 read drive", m_drive, 1);
        chk("R3 read dir", m_wr, 0);
        bus_rdata = 16'hA5C3;
        finish_access();
        chk("R4 rd_valid", rd_valid, 1);
        chk("R4 rd_data", rd_data, 16'hA5C3);
        chk("R4 released", m_drive, 0);
        step();
        chk("R4 rd_valid one cycle", rd_valid, 0);
    endtask

    task automatic t_full();
        bus_grant = 1'b0;
        push(1'b1, 16'h0100, 16'h1111);
        push(1'b1, 16'h0200, 16'h2222);
        chk("R2 full", req_ready, 0);
        push(1'b1, 16'h0300, 16'h3333);
        bus_grant = 1'b1;
        step();
        chk("R2 first entry", m_addr, 16'h0100);
        finish_access();
        chk("R2 room again", req_ready, 1);
        step();
        chk("R2 second entry", m_addr, 16'h0200);
        chk("R2 second data", m_wdata, 16'h2222);
        finish_access();
        step();
        chk("R2 overflow discarded", m_drive, 0);
    endtask

    task automatic t_wb();
        bus_grant = 1'b0;
        push(1'b1, 16'h0C00, 16'hC0DE);
        push(1'b0, 16'h0D00, 16'h0000);
        bus_grant = 1'b1;
        step();
        chk("R3 drive C", m_addr, 16'h0C00);
        wb_hold = 1'b1; bus_rdy = 1'b1; s_req = 1'b1;
        step();
        s_req = 1'b0; bus_rdy = 1'b0;
        chk("R5 released", m_drive, 0);
        chk("R5 wr floated", m_wr, 0);
        chk("R9 no ack during wb", s_ack, 0);
        chk("R9 pending", s_pending, 1);
        step();
        step();
        chk("R5 still released", m_drive, 0);
        chk("R9 still no ack", s_ack, 0);
        wb_hold = 1'b0;
        step();
        chk("R6 retry drive", m_drive, 1);
        chk("R6 retry start", m_start, 1);
        chk("R6 retry addr", m_addr, 16'h0C00);
        chk("R6 retry wdata", m_wdata, 16'hC0DE);
        chk("R6 retry dir", m_wr, 1);
        chk("R9 ack after wb", s_ack, 1);
        chk("R9 pending cleared", s_pending, 0);
        finish_access();
        chk("R9 ack one cycle", s_ack, 0);
        step();
        chk("R6 next in order", m_addr, 16'h0D00);
        chk("R6 next dir", m_wr, 0);
        finish_access();
    endtask

    task automatic t_grant_loss();
        push(1'b1, 16'h0E00, 16'h0E0E);
        step();
        chk("R7 driving", m_drive, 1);
        bus_grant = 1'b0;
        step();
        chk("R7 released", m_drive, 0);
        step();
        chk("R7 held off", m_drive, 0);
        bus_grant = 1'b1;
        step();
        chk("R7 retry start", m_start, 1);
        chk("R7 retry addr", m_addr, 16'h0E00);
        finish_access();
    endtask

    task automatic t_slave_free();
        s_req = 1'b1;
        step();
        s_req = 1'b0;
        chk("R10 ack", s_ack, 1);
        chk("R10 not pending", s_pending, 0);
        step();
        chk("R10 ack one cycle", s_ack, 0);
    endtask

    task automatic t_wb_idle();
        bus_grant = 1'b0;
        wb_hold = 1'b1;
        push(1'b0, 16'h0F00, 16'h0000);
        bus_grant = 1'b1;
        step();
        chk("R11 wb blocks start", m_drive, 0);
        step();
        chk("R11 wb still blocks", m_drive, 0);
        wb_hold = 1'b0;
        step();
        chk("R11 starts after wb", m_drive, 1);
        chk("R11 addr", m_addr, 16'h0F00);
        finish_access();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_full();
        t_wb();
        t_grant_loss();
        t_slave_free();
        t_wb_idle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule